// File: doc/BRIEF.md
# Key-Guarded Interrupt Configuration Register

This block is the configuration and status word of an interrupt controller, seen from a 32-bit register bus. Every write presents a 16-bit key in the upper half of the word. The block acts on a group of control bits only when that key matches the one assigned to the group. A write with any other key leaves that group untouched and raises no error.

The stored part is small: two persistent control levels, one that turns off the hardware register save on interrupt entry and one that turns off nesting. Both are active (the feature is on) when the stored bit is 0. The other writable bits are commands. They set or clear a pending NMI flag and a pending exception flag, request a reset of the interrupt controller with no key needed, or request a full system reset. Each reset request leaves the block as a pulse one clock long. A separate read-only status word shows what the controller core reports: its nesting depth and its global active and global pending indications.

Top module: `irq_cfg_guard`

## Requirements
- R1: After reset, stack_save_off, nest_off, nmi_pend, exc_pend, ctrl_rst_pulse and sys_rst_pulse are all 0.
- R2: A write whose bits 31:16 equal 0xFA05 loads bit 0 into stack_save_off and bit 1 into nest_off, visible from the clock edge that takes the write.
- R3: A write whose bits 31:16 differ from 0xFA05 leaves stack_save_off and nest_off unchanged.
- R4: With bits 31:16 equal to 0xBCAF, bit 2 sets nmi_pend, bit 3 clears nmi_pend, bit 4 sets exc_pend and bit 5 clears exc_pend; unwritten flags keep their value.
- R5: Bits 5:2 have no effect on nmi_pend or exc_pend when bits 31:16 differ from 0xBCAF.
- R6: When the set and clear bits of one flag are both 1 in an accepted write, that flag becomes 0.
- R7: A write with bits 31:16 equal to 0xBEEF and bit 7 at 1 makes sys_rst_pulse 1 for exactly the one cycle after the write; bit 7 with any other key gives no pulse.
- R8: A write with bit 6 at 1 makes ctrl_rst_pulse 1 for exactly the one cycle after the write, whatever bits 31:16 hold.
- R9: cfg_rdata carries stack_save_off in bit 0 and nest_off in bit 1; every other bit reads 0, since keys, commands and reset requests are write-only.
- R10: stat_rdata carries nest_depth zero-extended in bits 7:0, glob_active in bit 8, glob_pending in bit 9 and 0 in bits 31:10; it follows its inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Written word: key in 31:16, command bits in 7:0 |
| nest_depth | input | 2 | Nesting depth from the controller core (0, 1 or 2) |
| glob_active | input | 1 | Some interrupt is being serviced |
| glob_pending | input | 1 | Some interrupt is pending |
| stack_save_off | output | 1 | 1 turns off hardware register save on entry |
| nest_off | output | 1 | 1 turns off interrupt nesting |
| nmi_pend | output | 1 | NMI pending flag |
| exc_pend | output | 1 | Exception pending flag |
| ctrl_rst_pulse | output | 1 | One-cycle controller reset request |
| sys_rst_pulse | output | 1 | One-cycle system reset request |
| cfg_rdata | output | 32 | Readable view of the configuration word |
| stat_rdata | output | 32 | Global status word |

## Verification
The assertions take for granted that the controller core never reports a nesting depth of 3, and the status checks only drive depths 0, 1 and 2. They also assume wr_data is meaningful only while cfg_wr is high; the bench changes wr_data and cfg_wr together half a cycle away from the sampling edge and drops cfg_wr after one cycle, so every pulse check sees exactly one accepted write. Wrong-key stimulus always carries command bits that would have acted under the right key, so an ignored write is visible at the outputs.

// File: rtl/irq_cfg_pkg.sv
`timescale 1ns/1ps
package irq_cfg_pkg;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;
    localparam int KEY_LSB    = DATA_W - KEY_W;

    // Group keys; group index order is used by the key decoder.
    localparam logic [KEY_W-1:0] KEY_CTRL = 16'hFA05;
    localparam logic [KEY_W-1:0] KEY_FLAG = 16'hBCAF;
    localparam logic [KEY_W-1:0] KEY_SYS  = 16'hBEEF;
    localparam int GRP_CTRL = 0;
    localparam int GRP_FLAG = 1;
    localparam int GRP_SYS  = 2;
    localparam int NUM_GRP  = 3;

    // Command bit positions inside the written word.
    localparam int B_STK_OFF  = 0;
    localparam int B_NEST_OFF = 1;
    localparam int B_NMI_SET  = 2;
    localparam int B_NMI_CLR  = 3;
    localparam int B_EXC_SET  = 4;
    localparam int B_EXC_CLR  = 5;
    localparam int B_CTRL_RST = 6;
    localparam int B_SYS_RST  = 7;

    // Status word layout.
    localparam int NEST_FIELD_W = 8;
    localparam int B_ACTIVE     = NEST_FIELD_W;
    localparam int B_PENDING    = NEST_FIELD_W + 1;

    typedef struct packed {
        logic stk_off;
        logic nest_off;
        logic ctrl_rst;
        logic sys_rst;
    } cfg_state_t;
endpackage

// File: rtl/irq_cfg_key_match.sv
`timescale 1ns/1ps
module irq_cfg_key_match #(
    parameter int KEY_W   = 16,
    parameter int NUM_GRP = 3
) (
    input  logic [KEY_W-1:0]         key_in,
    input  logic [NUM_GRP*KEY_W-1:0] key_table,
    output logic [NUM_GRP-1:0]       grp_hit
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_cmp
        assign grp_hit[g] = (key_in == key_table[g*KEY_W +: KEY_W]);
    end
endmodule

// File: rtl/irq_cfg_flag_cell.sv
`timescale 1ns/1ps
module irq_cfg_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i) flag_d = 1'b1;
        if (clr_i) flag_d = 1'b0;   // clear dominates
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> !flag_o);
    assert_set_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> flag_o);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_cfg_status_pack.sv
`timescale 1ns/1ps
module irq_cfg_status_pack #(
    parameter int DATA_W       = 32,
    parameter int DEPTH_W      = 2,
    parameter int NEST_FIELD_W = 8
) (
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic               active_i,
    input  logic               pending_i,
    output logic [DATA_W-1:0]  word_o
);
    localparam int B_ACT = NEST_FIELD_W;
    localparam int B_PND = NEST_FIELD_W + 1;

    always_comb begin
        word_o = '0;
        word_o[NEST_FIELD_W-1:0] = NEST_FIELD_W'(depth_i);
        word_o[B_ACT] = active_i;
        word_o[B_PND] = pending_i;
    end
endmodule

// File: rtl/irq_cfg_guard.sv
`timescale 1ns/1ps
module irq_cfg_guard
    import irq_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        nest_depth,
    input  logic              glob_active,
    input  logic              glob_pending,
    output logic              stack_save_off,
    output logic              nest_off,
    output logic              nmi_pend,
    output logic              exc_pend,
    output logic              ctrl_rst_pulse,
    output logic              sys_rst_pulse,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] stat_rdata
);
    localparam int NUM_FLAG = 2;
    localparam logic [NUM_GRP*KEY_W-1:0] KEY_TABLE = {KEY_SYS, KEY_FLAG, KEY_CTRL};

    logic [KEY_W-1:0]   key;
    logic [NUM_GRP-1:0] hit;
    logic               unused_mid;

    assign key        = wr_data[DATA_W-1:KEY_LSB];
    assign unused_mid = ^wr_data[KEY_LSB-1:B_SYS_RST+1];

    irq_cfg_key_match #(.KEY_W(KEY_W), .NUM_GRP(NUM_GRP)) u_keys (
        .key_in   (key),
        .key_table(KEY_TABLE),
        .grp_hit  (hit)
    );

    // Control levels and reset pulses.
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ctrl_rst = cfg_wr && wr_data[B_CTRL_RST];
        st_d.sys_rst  = cfg_wr && hit[GRP_SYS] && wr_data[B_SYS_RST];
        if (cfg_wr && hit[GRP_CTRL]) begin
            st_d.stk_off  = wr_data[B_STK_OFF];
            st_d.nest_off = wr_data[B_NEST_OFF];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Pending flags.
    logic [NUM_FLAG-1:0] fl_set, fl_clr, fl_q;
    logic                flag_wr;
    assign flag_wr = cfg_wr && hit[GRP_FLAG];
    assign fl_set  = {wr_data[B_EXC_SET], wr_data[B_NMI_SET]} & {NUM_FLAG{flag_wr}};
    assign fl_clr  = {wr_data[B_EXC_CLR], wr_data[B_NMI_CLR]} & {NUM_FLAG{flag_wr}};

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        irq_cfg_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (fl_set[f]),
            .clr_i (fl_clr[f]),
            .flag_o(fl_q[f])
        );
    end

    irq_cfg_status_pack #(
        .DATA_W(DATA_W), .DEPTH_W(2), .NEST_FIELD_W(NEST_FIELD_W)
    ) u_stat (
        .depth_i  (nest_depth),
        .active_i (glob_active),
        .pending_i(glob_pending),
        .word_o   (stat_rdata)
    );

    assign stack_save_off = st_q.stk_off;
    assign nest_off       = st_q.nest_off;
    assign ctrl_rst_pulse = st_q.ctrl_rst;
    assign sys_rst_pulse  = st_q.sys_rst;
    assign nmi_pend       = fl_q[0];
    assign exc_pend       = fl_q[1];

    always_comb begin
        cfg_rdata             = '0;
        cfg_rdata[B_STK_OFF]  = st_q.stk_off;
        cfg_rdata[B_NEST_OFF] = st_q.nest_off;
    end

    assert_ctrl_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && key != KEY_CTRL) |=> ($stable(stack_save_off) && $stable(nest_off)));
    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && key == KEY_CTRL) |=> (stack_save_off == $past(wr_data[B_STK_OFF])));
    assert_sys_pulse_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_pulse |-> $past(cfg_wr && key == KEY_SYS && wr_data[B_SYS_RST]));
    assert_sys_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_pulse && !cfg_wr) |=> !sys_rst_pulse);
    assert_ctrl_pulse_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_pulse |-> $past(cfg_wr && wr_data[B_CTRL_RST]));
    assert_depth_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth != 2'd3);
endmodule

// File: tb/sim_irq_cfg_guard.sv
`timescale 1ns/1ps
module sim_irq_cfg_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  nest_depth = '0;
    logic        glob_active = 1'b0;
    logic        glob_pending = 1'b0;
    logic        stack_save_off, nest_off, nmi_pend, exc_pend;
    logic        ctrl_rst_pulse, sys_rst_pulse;
    logic [31:0] cfg_rdata, stat_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    irq_cfg_guard u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write; returns just after the capturing edge.
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; wr_data = d;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_wr = 1'b0; wr_data = '0;
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] outs();
        return {26'b0, stack_save_off, nest_off, nmi_pend, exc_pend, ctrl_rst_pulse, sys_rst_pulse};
    endfunction

    task automatic t_reset();
        chk("R1 reset outputs", outs(), 32'h0);
    endtask

    task automatic t_ctrl_bits();
        wr(32'hFA05_0003); idle();
        chk("R2 both off", {stack_save_off, nest_off}, 2'b11);
        wr(32'hFA05_0002); idle();
        chk("R2 stack on nest off", {stack_save_off, nest_off}, 2'b01);
    endtask

    task automatic t_wrong_key();
        wr(32'hBCAF_0001); idle();
        chk("R3 flag key no ctrl change", {stack_save_off, nest_off}, 2'b01);
        wr(32'hFA04_0001); idle();
        chk("R3 near key no ctrl change", {stack_save_off, nest_off}, 2'b01);
    endtask

    task automatic t_flags();
        wr(32'hBCAF_0004); idle();
        chk("R4 nmi set", {nmi_pend, exc_pend}, 2'b10);
        wr(32'hBCAF_0010); idle();
        chk("R4 exc set", {nmi_pend, exc_pend}, 2'b11);
        wr(32'hBCAF_0008); idle();
        chk("R4 nmi clear", {nmi_pend, exc_pend}, 2'b01);
        wr(32'hBCAF_0020); idle();
        chk("R4 exc clear", {nmi_pend, exc_pend}, 2'b00);
    endtask

    task automatic t_flag_badkey();
        wr(32'hFA05_0016); idle();
        chk("R5 set ignored", {nmi_pend, exc_pend}, 2'b00);
        wr(32'hBCAF_0014); idle();
        wr(32'hBEEF_0028); idle();
        chk("R5 clear ignored", {nmi_pend, exc_pend}, 2'b11);
    endtask

    task automatic t_both();
        wr(32'hBCAF_003C); idle();
        chk("R6 clear wins", {nmi_pend, exc_pend}, 2'b00);
    endtask

    task automatic t_sys();
        wr(32'hBEEF_0080);
        chk("R7 pulse high", sys_rst_pulse, 1'b1);
        idle();
        chk("R7 pulse gone", sys_rst_pulse, 1'b0);
        wr(32'hFA05_0081);
        chk("R7 wrong key no pulse", sys_rst_pulse, 1'b0);
        idle();
    endtask

    task automatic t_ctrl_rst();
        wr(32'h1234_0040);
        chk("R8 pulse any key", {ctrl_rst_pulse, sys_rst_pulse}, 2'b10);
        idle();
        chk("R8 pulse gone", ctrl_rst_pulse, 1'b0);
    endtask

    task automatic t_readback();
        wr(32'hFA05_00FE); idle();
        chk("R9 readback", cfg_rdata, 32'h0000_0002);
        chk("R9 flags untouched by ctrl key", {nmi_pend, exc_pend}, 2'b00);
    endtask

    task automatic t_status();
        nest_depth = 2'd2; glob_active = 1'b1; glob_pending = 1'b0; #1;
        chk("R10 depth2 active", stat_rdata, 32'h0000_0102);
        nest_depth = 2'd1; glob_active = 1'b0; glob_pending = 1'b1; #1;
        chk("R10 depth1 pending", stat_rdata, 32'h0000_0201);
        nest_depth = 2'd0; glob_active = 1'b0; glob_pending = 1'b0; #1;
        chk("R10 idle", stat_rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_ctrl_bits();
        t_wrong_key();
        t_flags();
        t_flag_badkey();
        t_both();
        t_sys();
        t_ctrl_rst();
        t_readback();
        t_status();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule